// File: doc/BRIEF.md
# Raster Sync and Window Timing Generator

This block walks a beam position across a composite-sync raster. A column counter advances once per clock over a fixed scanline length, and a row counter advances once per scanline over a fixed frame height. From that position the block drives an active-low horizontal sync, an active-low composite sync that carries the vertical interval, and two window qualifiers. `pix_active` marks the cycles in which a downstream colour stage must present a pixel. `fetch_active` opens a fixed number of cycles earlier, so that a memory stage can have display data ready before the first pixel of each group.

Vertical sync does not end on a line boundary. It is released half-way along its last line. All geometry is set by parameters. The defaults give a 1024-cycle scanline, a 312-line frame and a 640 by 256 visible area. Every output is registered, and the `x` and `y` outputs are registered alongside the flags. A consumer therefore always sees the flags that belong to the position shown on the same cycle.

Top module: `raster_timing_gen`

## Requirements
- R1: Within a scanline, `x` rises by exactly one on every clock and `y` holds its value.
- R2: `hsync_n` is 0 while `x` is in 0..74 and 1 for every other `x`.
- R3: `csync_n` is 0 from line 0, x 0 through line 2, x 511. It is 1 from line 2, x 512 until the next frame starts. Both limits are inclusive.
- R4: On an active line, `pix_active` is 1 exactly for `x` from 264 up to and including 903, a span of 640.
- R5: Active lines are `y` from 38 up to and including 293, a span of 256. On every other line, `pix_active` and `fetch_active` are both 0.
- R6: On an active line, `fetch_active` is 1 exactly for `x` from 256 up to and including 895. This is the pixel span shifted 8 cycles earlier.
- R7: After `x` = 1023, the next `x` is 0 and `y` increments. After line 311 ends, `y` returns to 0.
- R8: While `rst` is high, the outputs are `x` = 0, `y` = 0, `hsync_n` = 1, `csync_n` = 1, `pix_active` = 0 and `fetch_active` = 0. On the first clock after `rst` falls, the outputs show position (0,0) with `hsync_n` = 0 and `csync_n` = 0. This also holds when reset is applied in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, low during the line-start pulse |
| csync_n | output | 1 | Composite sync, low during the vertical interval |
| x | output | $clog2(H_TOTAL) | Column of the position shown on this cycle |
| y | output | $clog2(V_TOTAL) | Row of the position shown on this cycle |
| pix_active | output | 1 | High where a pixel must be produced |
| fetch_active | output | 1 | High where display memory should be prefetched |

## Verification
Each position reaches the outputs one clock edge after the internal counter holds it. The first edge after reset release shows (0,0), so after N edges the outputs show linear position N-1. The bench counts edges since reset release, derives the expected position from that count, and samples on the falling edge. It does not wait for a sync edge to synchronise. The default geometry is probed at chosen positions that straddle every edge in its first 40 lines. A second instance with a small geometry is compared against a bench-side model on every cycle, across many frames. That instance covers the bottom of the window and the frame wrap within the run length.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Output qualifiers, registered together so they stay aligned with x/y.
    typedef struct packed {
        logic hsync_n;
        logic csync_n;
        logic pix;
        logic fetch;
    } raster_flags_t;

    localparam raster_flags_t FLAGS_IDLE = '{hsync_n: 1'b1, csync_n: 1'b1, pix: 1'b0, fetch: 1'b0};

    // True when v lies in [lo, lo+len).
    function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                     input int unsigned len);
        return (v >= lo) && (v < lo + len);
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int unsigned H_TOTAL = 1024,
    parameter int unsigned V_TOTAL = 312
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(H_TOTAL)-1:0] pos_x,
    output logic [$clog2(V_TOTAL)-1:0] pos_y
);
    localparam int unsigned XW = $clog2(H_TOTAL);
    localparam int unsigned YW = $clog2(V_TOTAL);
    localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_x <= '0;
            pos_y <= '0;
        end else if (pos_x == X_LAST) begin
            pos_x <= '0;
            pos_y <= (pos_y == Y_LAST) ? '0 : pos_y + YW'(1);
        end else begin
            pos_x <= pos_x + XW'(1);
        end
    end

    AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
        pos_x != X_LAST |=> pos_x == $past(pos_x) + XW'(1) && pos_y == $past(pos_y)); // R1
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        pos_x == X_LAST && pos_y != Y_LAST |=> pos_x == '0 && pos_y == $past(pos_y) + YW'(1)); // R7
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        pos_x == X_LAST && pos_y == Y_LAST |=> pos_x == '0 && pos_y == '0); // R7

endmodule

// File: rtl/raster_sync_decode.sv
module raster_sync_decode #(
    parameter int unsigned H_TOTAL        = 1024,
    parameter int unsigned V_TOTAL        = 312,
    parameter int unsigned HSYNC_LEN      = 75,
    parameter int unsigned VSYNC_END_LINE = 2,
    parameter int unsigned VSYNC_END_X    = H_TOTAL / 2
) (
    input  logic [$clog2(H_TOTAL)-1:0] pos_x,
    input  logic [$clog2(V_TOTAL)-1:0] pos_y,
    output logic                       hsync_n,
    output logic                       csync_n
);
    logic in_vsync;

    always_comb begin
        hsync_n  = !(32'(pos_x) < HSYNC_LEN);
        // Vertical interval ends part-way along its last line.
        in_vsync = (32'(pos_y) < VSYNC_END_LINE) ||
                   ((32'(pos_y) == VSYNC_END_LINE) && (32'(pos_x) < VSYNC_END_X));
        csync_n  = !in_vsync;
    end

endmodule

// File: rtl/raster_window_decode.sv
module raster_window_decode import raster_pkg::*; #(
    parameter int unsigned H_TOTAL    = 1024,
    parameter int unsigned V_TOTAL    = 312,
    parameter int unsigned PIX_X0     = 264,
    parameter int unsigned PIX_W      = 640,
    parameter int unsigned PIX_Y0     = 38,
    parameter int unsigned PIX_H      = 256,
    parameter int unsigned FETCH_LEAD = 8
) (
    input  logic [$clog2(H_TOTAL)-1:0] pos_x,
    input  logic [$clog2(V_TOTAL)-1:0] pos_y,
    output logic                       pix,
    output logic                       fetch
);
    logic line_ok;

    assign line_ok = in_span(32'(pos_y), PIX_Y0, PIX_H);
    assign pix     = line_ok && in_span(32'(pos_x), PIX_X0, PIX_W);

    generate
        if (FETCH_LEAD == 0) begin : g_no_lead
            assign fetch = pix;
        end else begin : g_lead
            assign fetch = line_ok && in_span(32'(pos_x), PIX_X0 - FETCH_LEAD, PIX_W);
        end
    endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import raster_pkg::*; #(
    parameter int unsigned H_TOTAL        = 1024,
    parameter int unsigned V_TOTAL        = 312,
    parameter int unsigned HSYNC_LEN      = 75,
    parameter int unsigned VSYNC_END_LINE = 2,
    parameter int unsigned VSYNC_END_X    = H_TOTAL / 2,
    parameter int unsigned PIX_X0         = 264,
    parameter int unsigned PIX_W          = 640,
    parameter int unsigned PIX_Y0         = 38,
    parameter int unsigned PIX_H          = 256,
    parameter int unsigned FETCH_LEAD     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       hsync_n,
    output logic                       csync_n,
    output logic [$clog2(H_TOTAL)-1:0] x,
    output logic [$clog2(V_TOTAL)-1:0] y,
    output logic                       pix_active,
    output logic                       fetch_active
);
    localparam int unsigned XW = $clog2(H_TOTAL);
    localparam int unsigned YW = $clog2(V_TOTAL);

    logic [XW-1:0] pos_x;
    logic [YW-1:0] pos_y;
    raster_flags_t next_flags;
    raster_flags_t flags_q;

    raster_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .pos_x (pos_x),
        .pos_y (pos_y)
    );

    raster_sync_decode #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HSYNC_LEN(HSYNC_LEN),
        .VSYNC_END_LINE(VSYNC_END_LINE), .VSYNC_END_X(VSYNC_END_X)
    ) u_sync (
        .pos_x   (pos_x),
        .pos_y   (pos_y),
        .hsync_n (next_flags.hsync_n),
        .csync_n (next_flags.csync_n)
    );

    raster_window_decode #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .PIX_X0(PIX_X0), .PIX_W(PIX_W),
        .PIX_Y0(PIX_Y0), .PIX_H(PIX_H), .FETCH_LEAD(FETCH_LEAD)
    ) u_win (
        .pos_x (pos_x),
        .pos_y (pos_y),
        .pix   (next_flags.pix),
        .fetch (next_flags.fetch)
    );

    // Output stage: position and its flags move together.
    always_ff @(posedge clk) begin
        if (rst) begin
            x       <= '0;
            y       <= '0;
            flags_q <= FLAGS_IDLE;
        end else begin
            x       <= pos_x;
            y       <= pos_y;
            flags_q <= next_flags;
        end
    end

    assign hsync_n      = flags_q.hsync_n;
    assign csync_n      = flags_q.csync_n;
    assign pix_active   = flags_q.pix;
    assign fetch_active = flags_q.fetch;

    AST_HS_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> x == '0); // R2
    AST_HS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> x == XW'(HSYNC_LEN)); // R2
    AST_VS_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(csync_n) |-> x == '0 && y == '0); // R3
    AST_VS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(csync_n) |-> x == XW'(VSYNC_END_X) && y == YW'(VSYNC_END_LINE)); // R3
    AST_PIX_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_active) |-> x == XW'(PIX_X0)); // R4
    AST_PIX_LINES: assert property (@(posedge clk) disable iff (rst)
        pix_active |-> 32'(y) >= PIX_Y0 && 32'(y) < PIX_Y0 + PIX_H); // R5
    AST_FETCH_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_active) |-> x == XW'(PIX_X0 - FETCH_LEAD)); // R6

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    // Default geometry.
    logic       hs0, cs0, pix0, fe0;
    logic [9:0] x0;
    logic [8:0] y0;
    raster_timing_gen u0 (
        .clk(clk), .rst(rst), .hsync_n(hs0), .csync_n(cs0), .x(x0), .y(y0),
        .pix_active(pix0), .fetch_active(fe0)
    );

    // Small geometry, so that whole frames fit in the run.
    logic       hs1, cs1, pix1, fe1;
    logic [5:0] x1;
    logic [4:0] y1;
    raster_timing_gen #(
        .H_TOTAL(64), .V_TOTAL(20), .HSYNC_LEN(5), .VSYNC_END_LINE(2), .VSYNC_END_X(32),
        .PIX_X0(20), .PIX_W(30), .PIX_Y0(4), .PIX_H(10), .FETCH_LEAD(8)
    ) u1 (
        .clk(clk), .rst(rst), .hsync_n(hs1), .csync_n(cs1), .x(x1), .y(y1),
        .pix_active(pix1), .fetch_active(fe1)
    );

    int checks = 0;
    int errors = 0;
    int edges  = 0;   // clock edges since reset release
    int cyc    = 0;
    bit done   = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    // Cycle-by-cycle model of the small geometry.
    always @(negedge clk) begin
        int p, mx, my;
        bit lines;
        if (!rst && edges >= 1 && !done) begin
            p  = edges - 1;
            mx = p % 64;
            my = (p / 64) % 20;
            lines = (my >= 4) && (my < 14);
            check("R7", "u1 x", int'(x1), mx);
            check("R7", "u1 y", int'(y1), my);
            check("R2", "u1 hsync_n", int'(hs1), (mx < 5) ? 0 : 1);
            check("R3", "u1 csync_n", int'(cs1), (my < 2 || (my == 2 && mx < 32)) ? 0 : 1);
            check("R5", "u1 pix_active", int'(pix1), (lines && mx >= 20 && mx < 50) ? 1 : 0);
            check("R6", "u1 fetch_active", int'(fe1), (lines && mx >= 12 && mx < 42) ? 1 : 0);
        end
    end

    // Probe table for the default geometry: row, column, and the flags {hsync_n, csync_n, pix, fetch}.
    localparam int NV = 18;
    localparam int unsigned VY [NV] = '{0, 0, 0, 1, 2, 2, 3, 37, 38, 38, 38, 38, 38, 38, 38, 38, 39, 39};
    localparam int unsigned VX [NV] = '{0, 74, 75, 0, 511, 512, 0, 300, 255, 256, 263, 264,
                                        895, 896, 903, 904, 10, 600};
    localparam logic [3:0]  VE [NV] = '{4'b0000, 4'b0000, 4'b1000, 4'b0000, 4'b1000, 4'b1100,
                                        4'b0100, 4'b1100, 4'b1100, 4'b1101, 4'b1101, 4'b1111,
                                        4'b1111, 4'b1110, 4'b1110, 4'b1100, 4'b0100, 4'b1111};

    task automatic goto(input int p);
        while (edges < p + 1) @(negedge clk);
    endtask

    task automatic check_idle(input string tag);
        check("R8", {tag, " x"}, int'(x0), 0);
        check("R8", {tag, " y"}, int'(y0), 0);
        check("R8", {tag, " hsync_n"}, int'(hs0), 1);
        check("R8", {tag, " csync_n"}, int'(cs0), 1);
        check("R8", {tag, " pix_active"}, int'(pix0), 0);
        check("R8", {tag, " fetch_active"}, int'(fe0), 0);
        check("R8", {tag, " u1 hsync_n"}, int'(hs1), 1);
    endtask

    task automatic check_first(input string tag);
        check("R8", {tag, " x"}, int'(x0), 0);
        check("R8", {tag, " y"}, int'(y0), 0);
        check("R8", {tag, " hsync_n"}, int'(hs0), 0);
        check("R8", {tag, " csync_n"}, int'(cs0), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("in reset");
        rst = 1'b0;
        @(negedge clk);
        check_first("first cycle");

        for (int i = 0; i < NV; i++) begin
            goto(int'(VY[i]) * 1024 + int'(VX[i]));
            check("R1", $sformatf("x at probe %0d", i), int'(x0), int'(VX[i]));
            check("R7", $sformatf("y at probe %0d", i), int'(y0), int'(VY[i]));
            check("R2", $sformatf("hsync_n at probe %0d", i), int'(hs0), int'(VE[i][3]));
            check("R3", $sformatf("csync_n at probe %0d", i), int'(cs0), int'(VE[i][2]));
            check("R4", $sformatf("pix_active at probe %0d", i), int'(pix0), int'(VE[i][1]));
            check("R6", $sformatf("fetch_active at probe %0d", i), int'(fe0), int'(VE[i][0]));
        end

        // Reset in the middle of a line.
        rst = 1'b1;
        @(negedge clk);
        check_idle("mid-run reset");
        rst = 1'b0;
        @(negedge clk);
        check_first("after mid-run reset");

        goto(3000);
        done = 1;
        summary();
        $finish;
    end

endmodule